// File: doc/BRIEF.md
# Immediate Prefix Extension Unit

This unit sits in the decode stage of a 32-bit RISC core and builds the 32-bit immediate operand of each immediate-format instruction. Such an instruction carries only a 16-bit field. On its own, that field is sign-extended to 32 bits. A separate prefix instruction can supply the upper half instead. The unit stores that half and joins it with the low field of the next instruction, with no sign extension.

The stored half lives for exactly one accepted instruction. Any accepted instruction that is not a prefix uses it up, whatever its format. While a prefix is waiting, the unit raises an interrupt-inhibit output. This keeps an interrupt from splitting the prefix from the instruction that consumes it. A stall freezes the unit. A flush discards the waiting prefix.

Top module: `imm_prefix_unit`

## Requirements
- R1: After synchronous reset, `imm_o` is 0 and both `prefix_pending_o` and `irq_inhibit_o` are 0.
- R2: An instruction is accepted in a cycle where `insn_valid_i`=1, `stall_i`=0 and `flush_i`=0. The opcode is `insn_i[31:26]`. An instruction is immediate-format when `insn_i[29]`=1, and its 16-bit field is `insn_i[15:0]`. A prefix is an instruction with opcode 101100 and `insn_i[25:16]`=0.
- R3: An accepted immediate-format instruction with no prefix waiting sets `imm_o`, one cycle later, to the sign extension of `insn_i[15:0]`.
- R4: An accepted prefix sets `prefix_pending_o` one cycle later, stores `insn_i[15:0]`, and leaves `imm_o` unchanged.
- R5: An accepted immediate-format instruction with a prefix waiting sets `imm_o`, one cycle later, to {stored half, `insn_i[15:0]`}.
- R6: Any accepted instruction that is not a prefix clears `prefix_pending_o` one cycle later. A register-format instruction (`insn_i[29]`=0) leaves `imm_o` unchanged.
- R7: In a cycle with `stall_i`=1 and `flush_i`=0, all outputs hold their values.
- R8: `flush_i`=1 clears `prefix_pending_o` one cycle later. The instruction presented in that cycle is discarded, and `imm_o` is unchanged.
- R9: `irq_inhibit_o` is 1 exactly when `prefix_pending_o` is 1.
- R10: When two prefixes are accepted back to back, only the second one's half is joined to the next immediate-format instruction.
- R11: Opcode 101100 with a nonzero value in `insn_i[25:16]` is an ordinary immediate-format instruction, not a prefix.
- R12: A cycle with `insn_valid_i`=0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_i | input | 32 | Fetched instruction word |
| insn_valid_i | input | 1 | Instruction word is valid |
| stall_i | input | 1 | Decode stage is stalled |
| flush_i | input | 1 | Pipeline flush |
| imm_o | output | 32 | Effective immediate of the last accepted immediate-format instruction |
| prefix_pending_o | output | 1 | A prefix is waiting to be consumed |
| irq_inhibit_o | output | 1 | Interrupts must not be taken |

## Verification
The bench targets the cases where the stored half must not leak or be lost.

| Case | What a faulty design would show |
|---|---|
| A register-format instruction consumes the prefix | The half would reappear on a later immediate |
| A stall while a prefix waits | The prefix would be consumed early, or its value changed |
| A flush lands on an immediate instruction | `imm_o` would be updated, or the prefix would survive |
| Two prefixes in a row | The older half would be used |
| Opcode 101100 with a nonzero register field | It would be misread as a prefix and set the pending flag |
| Sign extension when no prefix waits | The upper bits would be wrong for a negative field |

// File: rtl/imm_prefix_pkg.sv
package imm_prefix_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = WORD_W / 2;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned REGF_W  = 5;
  localparam logic [OPC_W-1:0] PFX_OPC = 6'b101100;
  // position of the immediate-format bit inside the opcode field
  localparam int unsigned FMT_POS = 3;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [REGF_W-1:0] rd;
    logic [REGF_W-1:0] ra;
    logic [HALF_W-1:0] low;
  } insn_fields_t;

  typedef struct packed {
    logic is_prefix;
    logic is_immfmt;
  } insn_class_t;

endpackage

// File: rtl/imm_prefix_decode.sv
module imm_prefix_decode
  import imm_prefix_pkg::*;
(
  input  logic [WORD_W-1:0] insn,
  output insn_class_t       cls,
  output logic [HALF_W-1:0] low_field
);

  insn_fields_t f;

  always_comb begin
    f             = insn_fields_t'(insn);
    cls.is_prefix = (f.opc == PFX_OPC) && (f.rd == '0) && (f.ra == '0);
    cls.is_immfmt = f.opc[FMT_POS];
    low_field     = f.low;
  end

endmodule

// File: rtl/imm_prefix_hold.sv
module imm_prefix_hold
  import imm_prefix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              flush,
  input  logic              is_prefix,
  input  logic [HALF_W-1:0] low_field,
  output logic              pend_q,
  output logic              inhibit_q,
  output logic [HALF_W-1:0] hi_q
);

  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (flush)       pend_d = 1'b0;
    else if (accept) pend_d = is_prefix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q    <= 1'b0;
      inhibit_q <= 1'b0;
      hi_q      <= '0;
    end else begin
      pend_q    <= pend_d;
      inhibit_q <= pend_d;
      if (accept && is_prefix) hi_q <= low_field;
    end
  end

endmodule

// File: rtl/imm_prefix_former.sv
module imm_prefix_former
  import imm_prefix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  insn_class_t       cls,
  input  logic              pend,
  input  logic [HALF_W-1:0] hi,
  input  logic [HALF_W-1:0] low_field,
  output logic [WORD_W-1:0] imm_q
);

  logic [WORD_W-1:0] formed;

  always_comb begin
    if (pend) formed = {hi, low_field};
    else      formed = {{(WORD_W-HALF_W){low_field[HALF_W-1]}}, low_field};
  end

  always_ff @(posedge clk) begin
    if (rst) imm_q <= '0;
    else if (accept && cls.is_immfmt && !cls.is_prefix) imm_q <= formed;
  end

endmodule

// File: rtl/imm_prefix_unit.sv
module imm_prefix_unit
  import imm_prefix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] insn_i,
  input  logic              insn_valid_i,
  input  logic              stall_i,
  input  logic              flush_i,
  output logic [WORD_W-1:0] imm_o,
  output logic              prefix_pending_o,
  output logic              irq_inhibit_o
);

  logic              accept;
  insn_class_t       cls;
  logic [HALF_W-1:0] low_field;
  logic [HALF_W-1:0] hi;

  assign accept = insn_valid_i && !stall_i && !flush_i;

  imm_prefix_decode u_dec (
    .insn      (insn_i),
    .cls       (cls),
    .low_field (low_field)
  );

  imm_prefix_hold u_hold (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .flush     (flush_i),
    .is_prefix (cls.is_prefix),
    .low_field (low_field),
    .pend_q    (prefix_pending_o),
    .inhibit_q (irq_inhibit_o),
    .hi_q      (hi)
  );

  imm_prefix_former u_form (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .cls       (cls),
    .pend      (prefix_pending_o),
    .hi        (hi),
    .low_field (low_field),
    .imm_q     (imm_o)
  );

endmodule

// File: rtl/imm_prefix_chk.sv
module imm_prefix_chk
  import imm_prefix_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] insn_i,
  input logic              insn_valid_i,
  input logic              stall_i,
  input logic              flush_i,
  input logic [WORD_W-1:0] imm_o,
  input logic              prefix_pending_o,
  input logic              irq_inhibit_o
);

  logic acc, pfx, fmt;
  assign acc = insn_valid_i && !stall_i && !flush_i;
  assign pfx = (insn_i[31:26] == PFX_OPC) && (insn_i[25:16] == '0);
  assign fmt = insn_i[29];

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !flush_i) |=> ($stable(imm_o) && $stable(prefix_pending_o))); // R7
  AST_FLUSH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (!prefix_pending_o && $stable(imm_o))); // R8
  AST_PREFIX_SET: assert property (@(posedge clk) disable iff (rst)
    (acc && pfx) |=> (prefix_pending_o && $stable(imm_o))); // R4
  AST_CONSUME: assert property (@(posedge clk) disable iff (rst)
    (acc && !pfx) |=> !prefix_pending_o); // R6
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (rst)
    (acc && fmt && !pfx && !prefix_pending_o) |=>
      (imm_o == {{16{$past(insn_i[15])}}, $past(insn_i[15:0])})); // R3
  AST_JOIN_LOW: assert property (@(posedge clk) disable iff (rst)
    (acc && fmt && !pfx && prefix_pending_o) |=> (imm_o[15:0] == $past(insn_i[15:0]))); // R5
  AST_INHIBIT_MATCH: assert property (@(posedge clk) disable iff (rst)
    irq_inhibit_o == prefix_pending_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!insn_valid_i && !flush_i) |=> ($stable(imm_o) && $stable(prefix_pending_o))); // R12

endmodule

bind imm_prefix_unit imm_prefix_chk u_chk (
  .clk              (clk),
  .rst              (rst),
  .insn_i           (insn_i),
  .insn_valid_i     (insn_valid_i),
  .stall_i          (stall_i),
  .flush_i          (flush_i),
  .imm_o            (imm_o),
  .prefix_pending_o (prefix_pending_o),
  .irq_inhibit_o    (irq_inhibit_o)
);

// File: tb/sim_imm_prefix_unit.sv
`timescale 1ns/1ps
module sim_imm_prefix_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = '0;
  logic        vld = 1'b0, stl = 1'b0, fls = 1'b0;
  logic [31:0] imm;
  logic        pend, inh;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  imm_prefix_unit u0 (
    .clk(clk), .rst(rst), .insn_i(insn), .insn_valid_i(vld), .stall_i(stl),
    .flush_i(fls), .imm_o(imm), .prefix_pending_o(pend), .irq_inhibit_o(inh)
  );

  localparam logic [5:0] OP_IMM = 6'b001000;
  localparam logic [5:0] OP_REG = 6'b100000;
  localparam logic [5:0] OP_PFX = 6'b101100;

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rd,
                                     input logic [4:0] ra, input logic [15:0] lo);
    return {op, rd, ra, lo};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at a falling edge, sample at the next falling edge
  task automatic step(input logic [31:0] w, input logic v, input logic s, input logic f);
    insn = w; vld = v; stl = s; fls = f;
    @(negedge clk);
    vld = 1'b0; stl = 1'b0; fls = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 imm", imm, 32'h0);
    chk("R1 pend", {31'b0, pend}, 32'h0);
    chk("R1 inhibit", {31'b0, inh}, 32'h0);
  endtask

  task automatic t_sext;
    step(mk(OP_IMM, 5'd3, 5'd4, 16'h8001), 1, 0, 0);
    chk("R3 negative", imm, 32'hFFFF8001);
    step(mk(OP_IMM, 5'd3, 5'd4, 16'h7FFF), 1, 0, 0);
    chk("R3 R2 positive", imm, 32'h00007FFF);
  endtask

  task automatic t_prefix;
    step(mk(OP_PFX, 5'd0, 5'd0, 16'h1234), 1, 0, 0);
    chk("R4 pend", {31'b0, pend}, 32'h1);
    chk("R9 inhibit", {31'b0, inh}, 32'h1);
    chk("R4 imm held", imm, 32'h00007FFF);
    step(mk(OP_IMM, 5'd1, 5'd2, 16'h8001), 1, 0, 0);
    chk("R5 joined", imm, 32'h12348001);
    chk("R6 cleared", {31'b0, pend}, 32'h0);
    chk("R9 inhibit low", {31'b0, inh}, 32'h0);
  endtask

  task automatic t_reg_consume;
    step(mk(OP_PFX, 5'd0, 5'd0, 16'hABCD), 1, 0, 0);
    step(mk(OP_REG, 5'd1, 5'd2, 16'h5555), 1, 0, 0);
    chk("R6 reg clears", {31'b0, pend}, 32'h0);
    chk("R6 reg imm held", imm, 32'h12348001);
    step(mk(OP_IMM, 5'd1, 5'd2, 16'h0005), 1, 0, 0);
    chk("R6 prefix gone", imm, 32'h00000005);
  endtask

  task automatic t_stall;
    step(mk(OP_PFX, 5'd0, 5'd0, 16'h00FF), 1, 0, 0);
    step(mk(OP_IMM, 5'd1, 5'd2, 16'h0001), 1, 1, 0);
    step(mk(OP_IMM, 5'd1, 5'd2, 16'h0001), 1, 1, 0);
    chk("R7 pend held", {31'b0, pend}, 32'h1);
    chk("R7 imm held", imm, 32'h00000005);
    step(mk(OP_IMM, 5'd1, 5'd2, 16'h0001), 1, 0, 0);
    chk("R7 released", imm, 32'h00FF0001);
  endtask

  task automatic t_flush;
    step(mk(OP_PFX, 5'd0, 5'd0, 16'h4444), 1, 0, 0);
    step(mk(OP_IMM, 5'd1, 5'd2, 16'h0009), 1, 0, 1);
    chk("R8 pend cleared", {31'b0, pend}, 32'h0);
    chk("R8 imm held", imm, 32'h00FF0001);
    step(mk(OP_IMM, 5'd1, 5'd2, 16'h8000), 1, 0, 0);
    chk("R8 no stale half", imm, 32'hFFFF8000);
  endtask

  task automatic t_double;
    step(mk(OP_PFX, 5'd0, 5'd0, 16'h1111), 1, 0, 0);
    step(mk(OP_PFX, 5'd0, 5'd0, 16'h2222), 1, 0, 0);
    chk("R10 still pending", {31'b0, pend}, 32'h1);
    step(mk(OP_IMM, 5'd1, 5'd2, 16'h0003), 1, 0, 0);
    chk("R10 second half", imm, 32'h22220003);
  endtask

  task automatic t_fake_prefix;
    step(mk(OP_PFX, 5'd1, 5'd0, 16'h9000), 1, 0, 0);
    chk("R11 no pend", {31'b0, pend}, 32'h0);
    chk("R11 as immediate", imm, 32'hFFFF9000);
    step(mk(OP_PFX, 5'd0, 5'd6, 16'h0042), 1, 0, 0);
    chk("R11 ra nonzero", imm, 32'h00000042);
  endtask

  task automatic t_idle;
    step(mk(OP_PFX, 5'd0, 5'd0, 16'h7777), 1, 0, 0);
    for (int i = 0; i < 3; i++) step(mk(OP_IMM, 5'd1, 5'd1, 16'h1234), 0, 0, 0);
    chk("R12 pend held", {31'b0, pend}, 32'h1);
    chk("R12 imm held", imm, 32'h00000042);
    step(mk(OP_IMM, 5'd1, 5'd2, 16'h0001), 1, 0, 0);
    chk("R12 joined after idle", imm, 32'h77770001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sext();
    t_prefix();
    t_reg_consume();
    t_stall();
    t_flush();
    t_double();
    t_fake_prefix();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule